// File: doc/BRIEF.md
# Resistance-to-Frequency Measurement Controller

This block sequences one resistance-to-frequency conversion channel. Software first starts a reference oscillation. During it, a time base counter counts system clock cycles up from zero while a measurement counter counts oscillator edges from a software preset. The phase ends normally when the measurement counter overflows. Software then starts a sensor oscillation (sensor A or sensor B). In that phase the time base counter counts down from the value it reached, and the phase ends normally when it reaches zero. The measurement counter value left after the sensor phase is the figure of merit. In each phase, the condition that normally ends the other phase is treated as an abnormal termination and raises an error flag.

The oscillator is external and arrives as the `osc_clk` input. It is resynchronized into the system clock domain before it is counted. A monitor output repeats the raw oscillator, or a divided-by-two copy of it, so that the frequency can be measured. A continuous mode disables every stop condition. In that mode the oscillator runs until software writes the trigger word with the active bit cleared. Five sticky flags, five enables and one request line report phase outcomes.

Top module: `rfm_ctrl`

## Requirements
- R1: After reset `osc_en`, `osc_sel`, `flags`, `irq`, `mc_value` and `tc_value` are all zero.
- R2: A trigger write while idle starts a phase. The trigger bits are bit0 reference, bit1 sensor A and bit2 sensor B, and when several bits are set, reference wins over A, which wins over B. `osc_sel` shows 01 for reference, 10 for sensor A, 11 for sensor B and 00 when idle, and `osc_en` is high whenever `osc_sel` is not 00. Every start loads the measurement counter from the preset. A reference start also clears the time base counter, while a sensor start keeps it. While idle, the counters hold.
- R3: A trigger write while a phase runs is ignored, except for a stop in continuous mode (R8).
- R4: The measurement counter advances once per rising edge of `osc_clk`. It changes on the third system clock edge after `osc_clk` rises, counting the first edge that samples it high. In the reference phase a measurement counter wrap from all-ones sets flag bit0 and returns to idle.
- R5: In the reference phase, the time base counter counts up one per cycle. If it wraps from all-ones before the measurement counter does, flag bit4 is set and the block returns to idle.
- R6: In a sensor phase, the time base counter counts down one per cycle. In the cycle it is seen at zero, the phase ends and sets flag bit1 (sensor A) or bit2 (sensor B). A sensor started with the time base at T sets its flag T+1 cycles after the start edge.
- R7: In a sensor phase, a measurement counter wrap while the time base is not zero sets flag bit3 and returns to idle.
- R8: In continuous mode no flag is set and both counters wrap freely. The phase ends only when software writes the trigger word with the active bit cleared.
- R9: When the divide control is 0, `mon_clk` follows `osc_clk`. When it is 1, `mon_clk` toggles on every rising edge of `osc_clk` since reset.
- R10: A clear write removes every flag whose data bit is 1, and data bits at 0 leave their flags alone. A hardware set in the same cycle as a clear of the same bit leaves the flag set.
- R11: `irq` is high exactly when some flag is set whose enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Oscillator clock from the analog cell |
| trg_we | input | 1 | Trigger word write strobe |
| trg_wdata | input | 3 | Trigger bits: 0 reference, 1 sensor A, 2 sensor B |
| ctl_we | input | 1 | Control write strobe |
| ctl_cont | input | 1 | Continuous oscillation mode |
| ctl_div2 | input | 1 | Monitor output divided by two |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 5 | Interrupt enables, one per flag |
| clr_we | input | 1 | Flag clear write strobe |
| clr_wdata | input | 5 | Flag clear mask, 1 clears |
| preset_we | input | 1 | Measurement preset write strobe |
| preset_wdata | input | CW | Measurement counter preset value |
| osc_en | output | 1 | Oscillator enable |
| osc_sel | output | 2 | Running phase code |
| mon_clk | output | 1 | Oscillator monitor clock |
| mc_value | output | CW | Measurement counter readback |
| tc_value | output | CW | Time base counter readback |
| flags | output | 5 | Flags: 0 ref done, 1 A done, 2 B done, 3 measurement overflow, 4 time base overflow |
| irq | output | 1 | Interrupt request |

## Verification
The coincidence of interest is a hardware flag set landing in the same cycle as a software clear of that same bit. To provoke it, the bench starts a sensor phase with the time base already at zero, which fixes the completion to the very next edge. It then issues the clear write so that it is sampled on that edge. The flag must still read 1 afterwards, and a later plain clear must remove it. A second coincidence is a measurement wrap and a time base event in one cycle. The stop logic resolves it in favour of the normal completion, and an in-RTL check keeps at most one cause active per cycle.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_REF  = 2'b01,
    PH_SNA  = 2'b10,
    PH_SNB  = 2'b11
  } phase_e;

  localparam int NFLG   = 5;
  localparam int F_REF  = 0;
  localparam int F_SNA  = 1;
  localparam int F_SNB  = 2;
  localparam int F_MOVF = 3;
  localparam int F_TOVF = 4;
endpackage

// File: rtl/rfm_osc_front.sv
module rfm_osc_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_clk,
  input  logic div_mode,
  output logic osc_rise,
  output logic mon_clk
);
  localparam int SHW = SYNC_STAGES + 1;

  logic [SHW-1:0] sh_q, sh_d;
  logic           half_q;

  always_comb begin
    sh_d     = {sh_q[SHW-2:0], osc_clk};
    osc_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // divide-by-two copy runs in the oscillator domain
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign mon_clk = div_mode ? half_q : osc_clk;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    osc_rise |=> !osc_rise); // R4
endmodule

// File: rtl/rfm_irq_flags.sv
module rfm_irq_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  input  logic         en_we,
  input  logic [N-1:0] en_data,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flg_q, flg_d, en_q, en_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb flg_d[i] = set_i[i] | (flg_q[i] & ~(clr_we & clr_data[i]));

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_o[i]); // R10
    AST_ZERO_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !clr_data[i] && !set_i[i]) |=> (flags_o[i] == $past(flags_o[i]))); // R10
  end

  always_comb en_d = en_we ? en_data : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      en_q  <= '0;
    end else begin
      flg_q <= flg_d;
      en_q  <= en_d;
    end
  end

  assign flags_o = flg_q;
  assign irq_o   = |(flg_q & en_q);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_o != '0)); // R11
endmodule

// File: rtl/rfm_ctrl.sv
module rfm_ctrl
  import rfm_pkg::*;
#(
  parameter int CW          = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_clk,
  input  logic            trg_we,
  input  logic [2:0]      trg_wdata,
  input  logic            ctl_we,
  input  logic            ctl_cont,
  input  logic            ctl_div2,
  input  logic            ien_we,
  input  logic [NFLG-1:0] ien_wdata,
  input  logic            clr_we,
  input  logic [NFLG-1:0] clr_wdata,
  input  logic            preset_we,
  input  logic [CW-1:0]   preset_wdata,
  output logic            osc_en,
  output logic [1:0]      osc_sel,
  output logic            mon_clk,
  output logic [CW-1:0]   mc_value,
  output logic [CW-1:0]   tc_value,
  output logic [NFLG-1:0] flags,
  output logic            irq
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic osc_rise;
  logic cont_q, cont_d, div_q, div_d;
  logic [CW-1:0] preset_q, preset_d, mc_q, mc_d, tc_q, tc_d;
  phase_e phase_q, phase_d, start_ph;
  logic running, is_ref, is_sns, start, active_bit, cont_stop;
  logic mc_wrap, tc_wrap, tc_hit, stop_any;
  logic [NFLG-1:0] flag_set;

  rfm_osc_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .osc_clk  (osc_clk),
    .div_mode (div_q),
    .osc_rise (osc_rise),
    .mon_clk  (mon_clk)
  );

  always_comb begin
    running  = (phase_q != PH_IDLE);
    is_ref   = (phase_q == PH_REF);
    is_sns   = (phase_q == PH_SNA) || (phase_q == PH_SNB);
    start    = !running && trg_we && (|trg_wdata);
    start_ph = trg_wdata[0] ? PH_REF : (trg_wdata[1] ? PH_SNA : PH_SNB);

    case (phase_q)
      PH_REF:  active_bit = trg_wdata[0];
      PH_SNA:  active_bit = trg_wdata[1];
      PH_SNB:  active_bit = trg_wdata[2];
      default: active_bit = 1'b1;
    endcase
    cont_stop = running && cont_q && trg_we && !active_bit;

    mc_wrap = running && osc_rise && (mc_q == CNT_MAX);
    tc_wrap = is_ref && (tc_q == CNT_MAX);
    tc_hit  = is_sns && (tc_q == '0);

    flag_set         = '0;
    flag_set[F_REF]  = !cont_q && is_ref && mc_wrap;
    flag_set[F_TOVF] = !cont_q && is_ref && tc_wrap && !mc_wrap;
    flag_set[F_SNA]  = !cont_q && (phase_q == PH_SNA) && tc_hit;
    flag_set[F_SNB]  = !cont_q && (phase_q == PH_SNB) && tc_hit;
    flag_set[F_MOVF] = !cont_q && is_sns && mc_wrap && !tc_hit;
    stop_any         = (|flag_set) || cont_stop;

    if (start)         phase_d = start_ph;
    else if (stop_any) phase_d = PH_IDLE;
    else               phase_d = phase_q;

    if (start)                    mc_d = preset_q;
    else if (running && osc_rise) mc_d = mc_q + 1'b1;
    else                          mc_d = mc_q;

    if (start && start_ph == PH_REF)     tc_d = '0;
    else if (is_ref)                     tc_d = tc_q + 1'b1;
    else if (is_sns && !(tc_hit && !cont_q)) tc_d = tc_q - 1'b1;
    else                                 tc_d = tc_q;

    cont_d   = ctl_we    ? ctl_cont     : cont_q;
    div_d    = ctl_we    ? ctl_div2     : div_q;
    preset_d = preset_we ? preset_wdata : preset_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      phase_q  <= PH_IDLE;
      mc_q     <= '0;
      tc_q     <= '0;
      cont_q   <= 1'b0;
      div_q    <= 1'b0;
      preset_q <= '0;
    end else begin
      phase_q  <= phase_d;
      mc_q     <= mc_d;
      tc_q     <= tc_d;
      cont_q   <= cont_d;
      div_q    <= div_d;
      preset_q <= preset_d;
    end
  end

  rfm_irq_flags #(.N(NFLG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_i    (flag_set),
    .clr_we   (clr_we),
    .clr_data (clr_wdata),
    .en_we    (ien_we),
    .en_data  (ien_wdata),
    .flags_o  (flags),
    .irq_o    (irq)
  );

  assign osc_sel  = phase_q;
  assign osc_en   = running;
  assign mc_value = mc_q;
  assign tc_value = tc_q;

  AST_REF_START_CLEARS_TB: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && trg_wdata[0]) |=> (tc_value == '0 && osc_sel == 2'b01)); // R2
  AST_IDLE_COUNTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!running && !start) |=> ($stable(mc_value) && $stable(tc_value))); // R2
  AST_RUN_IGNORES_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n_s)
    (running && trg_we && !stop_any) |=> $stable(osc_sel)); // R3
  AST_SINGLE_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(flag_set)); // R7
  AST_SENSOR_WAITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (is_sns && tc_value != '0) |-> !(flag_set[F_SNA] || flag_set[F_SNB])); // R6
  AST_CONT_SILENT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cont_q && running) |=> ($past(flags) == flags || $past(clr_we))); // R8
endmodule

// File: tb/sim_rfm_ctrl.sv
module sim_rfm_ctrl;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic osc_clk;
  logic trg_we, ctl_we, ctl_cont, ctl_div2, ien_we, clr_we, preset_we;
  logic [2:0] trg_wdata;
  logic [4:0] ien_wdata, clr_wdata;
  logic [CW-1:0] preset_wdata;
  logic osc_en, mon_clk, irq;
  logic [1:0] osc_sel;
  logic [CW-1:0] mc_value, tc_value;
  logic [4:0] flags;

  rfm_ctrl #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk),
    .trg_we(trg_we), .trg_wdata(trg_wdata),
    .ctl_we(ctl_we), .ctl_cont(ctl_cont), .ctl_div2(ctl_div2),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .preset_we(preset_we), .preset_wdata(preset_wdata),
    .osc_en(osc_en), .osc_sel(osc_sel), .mon_clk(mon_clk),
    .mc_value(mc_value), .tc_value(tc_value), .flags(flags), .irq(irq)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0, n_pulse = 0;
  bit div_cfg = 1'b0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [4:0] flg;
    logic       rq;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_at(int at, logic [4:0] f, logic r, string req);
    sb_q.push_back('{at, f, r, req});
  endtask

  // monitor: pops expected flag/irq items in the cycle they fall due
  always @(negedge clk) begin
    exp_t e;
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      e = sb_q.pop_front();
      chk({e.req, " due cycle"}, cyc, e.at);
      chk({e.req, " flags/irq"}, {flags, irq}, {e.flg, e.rq});
    end
  end

  task automatic wr_trg(logic [2:0] d);
    trg_we = 1'b1; trg_wdata = d; @(negedge clk); trg_we = 1'b0; trg_wdata = '0;
  endtask
  task automatic wr_ctl(logic c, logic dv);
    ctl_we = 1'b1; ctl_cont = c; ctl_div2 = dv; div_cfg = dv;
    @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic wr_ien(logic [4:0] d);
    ien_we = 1'b1; ien_wdata = d; @(negedge clk); ien_we = 1'b0;
  endtask
  task automatic wr_clr(logic [4:0] d);
    clr_we = 1'b1; clr_wdata = d; @(negedge clk); clr_we = 1'b0; clr_wdata = '0;
  endtask
  task automatic wr_pre(logic [CW-1:0] d);
    preset_we = 1'b1; preset_wdata = d; @(negedge clk); preset_we = 1'b0;
  endtask
  task automatic osc_pulse();
    osc_clk = 1'b1; n_pulse++;
    #1 chk("R9 monitor high", mon_clk, div_cfg ? (n_pulse % 2) : 1);
    @(negedge clk); @(negedge clk);
    osc_clk = 1'b0;
    #1 chk("R9 monitor low", mon_clk, div_cfg ? (n_pulse % 2) : 0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int t0, t2, tb;
    rst_n = 1'b0; osc_clk = 1'b0;
    trg_we = 0; ctl_we = 0; ctl_cont = 0; ctl_div2 = 0; ien_we = 0;
    clr_we = 0; preset_we = 0; trg_wdata = '0; ien_wdata = '0;
    clr_wdata = '0; preset_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 osc_en", osc_en, 0);
    chk("R1 osc_sel", osc_sel, 0);
    chk("R1 flags+irq", {flags, irq}, 0);
    chk("R1 counters", {mc_value, tc_value}, 0);

    wr_ien(5'b00001);
    wr_pre(8'hFF);

    // R2 priority, R4 reference normal completion
    wr_trg(3'b111); t0 = cyc;
    chk("R2 priority picks reference", osc_sel, 2'b01);
    chk("R2 reference clears time base", tc_value, 0);
    chk("R2 preset loaded", mc_value, 8'hFF);
    expect_at(t0 + 3, 5'b00001, 1'b1, "R4");
    osc_pulse();
    repeat (2) @(negedge clk);
    chk("R4 idle after completion", osc_en, 0);
    chk("R4 measurement wrapped", mc_value, 0);
    chk("R4 time base at stop", tc_value, 3);

    // R6 sensor A normal completion
    wr_trg(3'b010); t0 = cyc;
    chk("R2 sensor A code", osc_sel, 2'b10);
    chk("R2 sensor keeps time base", tc_value, 3);
    expect_at(t0 + 4, 5'b00011, 1'b1, "R6");
    repeat (6) @(negedge clk);
    chk("R6 time base at zero", tc_value, 0);
    chk("R6 idle", osc_en, 0);

    // R10 set and clear in the same cycle
    wr_trg(3'b010); t0 = cyc;
    expect_at(t0 + 1, 5'b00011, 1'b1, "R10 set beats clear");
    wr_clr(5'b00010);
    wr_clr(5'b00010);
    chk("R10 plain clear", flags, 5'b00001);
    wr_clr(5'b00000);
    chk("R10 zero mask no effect", flags, 5'b00001);
    wr_ien(5'b11110);
    chk("R11 flag without enable", irq, 0);
    wr_clr(5'b00001);
    chk("R10 all clear", flags, 0);

    // R5 time base overflow, R3 ignored triggers
    wr_ien(5'b00010);
    wr_trg(3'b001); t0 = cyc;
    wr_trg(3'b010);
    chk("R3 sensor A write ignored", osc_sel, 2'b01);
    wr_trg(3'b100);
    chk("R3 sensor B write ignored", osc_sel, 2'b01);
    expect_at(t0 + 256, 5'b10000, 1'b0, "R5");
    while (cyc < t0 + 258) @(negedge clk);
    chk("R5 idle after error", osc_en, 0);
    chk("R5 time base wrapped", tc_value, 0);
    wr_ien(5'b10000);
    chk("R11 enabled flag raises irq", irq, 1);

    // R8 continuous mode
    wr_clr(5'b11111);
    chk("R10 clear all", {flags, irq}, 0);
    wr_ctl(1'b1, 1'b0);
    wr_trg(3'b001); t0 = cyc;
    while (cyc < t0 + 300) @(negedge clk);
    chk("R8 still running past wrap", osc_en, 1);
    chk("R8 no flag on time base wrap", flags, 0);
    osc_pulse();
    chk("R8 measurement wraps silently", mc_value, 0);
    chk("R8 no flag on measurement wrap", flags, 0);
    wr_trg(3'b001);
    chk("R8 active bit kept running", osc_en, 1);
    while (cyc < t0 + 355) @(negedge clk);
    wr_trg(3'b000); t2 = cyc;
    tb = (t2 - t0) % 256;
    chk("R8 stopped by clearing trigger", osc_en, 0);
    chk("R8 time base free-running", tc_value, tb);
    chk("R8 no flags", flags, 0);

    // R7 sensor B measurement overflow
    wr_ctl(1'b0, 1'b0);
    wr_trg(3'b100); t0 = cyc;
    chk("R2 sensor B code", osc_sel, 2'b11);
    expect_at(t0 + 3, 5'b01000, 1'b0, "R7");
    osc_pulse();
    repeat (2) @(negedge clk);
    chk("R7 idle after error", osc_en, 0);
    chk("R7 time base stopped", tc_value, tb - 3);

    // R9 divided monitor
    wr_ctl(1'b0, 1'b1);
    chk("R9 divided level", mon_clk, n_pulse % 2);
    osc_pulse();
    osc_pulse();

    while (sb_q.size() > 0) @(negedge clk);
    summary();
  end
endmodule